// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block follows a single transmit queue that runs with hardware-managed block acknowledgement. It keeps a sliding window of at most 64 consecutive descriptors. The window starts at the queue's read index. For every descriptor in the window it holds three flags: sent, acknowledged, and missed by the last block-ack. Descriptors are taken into the window in order as they are transmitted for the first time. Acknowledgements can then arrive in any order, carried in a 64-bit block-ack bitmap.

Each cycle the block presents one descriptor index for the scheduler to send. A descriptor that a block-ack reported as missed is always preferred over a fresh one, and among the candidates the lowest window offset wins. Whenever the acknowledged frames at the head of the window form a contiguous run, the read index moves past them. A space-left flag tells the scheduler whether the window may take in another descriptor. Two values are programmable: the maximum window size and the limit on frames in flight. Ring indices are 8 bits wide and wrap modulo 256.

Top module: `baWindowTracker`

## Requirements
- R1: After reset the read index is 0, the window is empty, and with the write index at 0 the block shows no offer and no space left.
- R2: With no retry pending and space left, the offer is the descriptor at read index + window span. A transmit-done pulse taken while an offer is valid marks that descriptor sent, and a fresh descriptor grows the span by one on the next cycle.
- R3: Space left is 1 exactly when the span is below min(max window size, 64) and below (write index − read index) mod 256. A max window size above 64 acts as 64.
- R4: No offer is shown while the number of in-flight frames is at or above the frame limit. In flight means sent, not acknowledged and not missed. A limit of 0 blocks every offer.
- R5: In a block-ack, bit i refers to the descriptor at start + i (mod 256). A set bit acknowledges that descriptor. A clear bit marks an unacknowledged, sent descriptor as missed. Bits that land on descriptors outside the sent part of the window have no effect.
- R6: On the cycle after a block-ack, the read index has advanced over the leading run of acknowledged descriptors and the span has shrunk by the same amount. Without a block-ack or a load, the read index holds.
- R7: Missed, unacknowledged descriptors are offered again before any fresh descriptor, lowest offset first. Resending a descriptor clears its missed flag.
- R8: A load pulse sets the read index to the load value and empties the window on the next cycle.
- R9: Priority per cycle is load, then block-ack, then transmit-done. A transmit-done pulse in the same cycle as a load or block-ack is dropped.
- R10: Index arithmetic wraps modulo 256, both for the offer and when the read index advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWinSize | input | 7 | Maximum window size (values above 64 act as 64) |
| cfgFrameLimit | input | 7 | Maximum frames in flight |
| wrIdx | input | 8 | Queue write index (one past the last queued descriptor) |
| loadValid | input | 1 | Restart the window at loadIdx |
| loadIdx | input | 8 | New read index for a load |
| baValid | input | 1 | Block-ack present this cycle |
| baStart | input | 8 | Ring index that bitmap bit 0 refers to |
| baBitmap | input | 64 | Acknowledge bitmap |
| txDone | input | 1 | The offered descriptor was transmitted |
| offerValid | output | 1 | An offer is available |
| offerIdx | output | 8 | Ring index of the offered descriptor |
| spaceLeft | output | 1 | Window may take in another descriptor |
| rdIdx | output | 8 | Current read index (start of window) |

## Verification
offerValid, offerIdx and spaceLeft are combinational in the registered window state, wrIdx and the two configuration inputs. They therefore follow an input change within the same cycle, and they follow a transmit-done, block-ack or load one clock edge later. The same holds for rdIdx, which changes only at the edge that accepts a block-ack or a load. The bench changes inputs just after the falling edge and compares all four outputs 1 ns later against a reference model indexed by absolute ring position. It then advances that model with the inputs that the next rising edge will capture. This way every comparison sees exactly the state that the previous edge produced.

// File: rtl/baWinPkg.sv
package baWinPkg;
  localparam int WIN_SLOTS = 64;
  localparam int OFF_W     = $clog2(WIN_SLOTS);
  localparam int CNT_W     = OFF_W + 1;
  localparam int IDX_W     = 8;

  typedef struct packed {
    logic             load;
    logic             applyBa;
    logic             markTx;
    logic             txNew;
    logic [OFF_W-1:0] txOff;
  } winStrobe_t;
endpackage

// File: rtl/baWinData.sv
module baWinData
  import baWinPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           strobe,
  input  logic [IDX_W-1:0]     loadIdx,
  input  logic [IDX_W-1:0]     baStart,
  input  logic [WIN_SLOTS-1:0] baBitmap,
  output logic [IDX_W-1:0]     rdIdx,
  output logic [CNT_W-1:0]     spanQ,
  output logic [WIN_SLOTS-1:0] sentQ,
  output logic [WIN_SLOTS-1:0] ackQ,
  output logic [WIN_SLOTS-1:0] missQ
);
  localparam logic [IDX_W-1:0] FWD_LIM  = IDX_W'(WIN_SLOTS);
  localparam logic [IDX_W-1:0] BACK_LIM = IDX_W'((1 << IDX_W) - WIN_SLOTS);
  localparam logic [WIN_SLOTS-1:0] ALL_ONES = {WIN_SLOTS{1'b1}};

  logic [IDX_W-1:0]     delta, negDelta;
  logic [WIN_SLOTS-1:0] ackOff, coverOff, newAck, newMiss;
  logic [CNT_W-1:0]     lead;

  function automatic logic [CNT_W-1:0] leadOnes(input logic [WIN_SLOTS-1:0] v);
    logic [CNT_W-1:0] cnt;
    logic stop;
    cnt  = '0;
    stop = 1'b0;
    for (int i = 0; i < WIN_SLOTS; i++) begin
      if (!stop) begin
        if (v[i]) cnt = cnt + CNT_W'(1);
        else      stop = 1'b1;
      end
    end
    return cnt;
  endfunction

  // Align the bitmap to window offsets (offset 0 = rdIdx)
  always_comb begin
    delta    = baStart - rdIdx;
    negDelta = rdIdx - baStart;
    if (delta < FWD_LIM) begin
      ackOff   = baBitmap << delta[OFF_W-1:0];
      coverOff = ALL_ONES << delta[OFF_W-1:0];
    end else if (delta >= BACK_LIM) begin
      ackOff   = baBitmap >> negDelta;
      coverOff = ALL_ONES >> negDelta;
    end else begin
      ackOff   = '0;
      coverOff = '0;
    end
    newAck  = ackQ | (ackOff & sentQ);
    newMiss = (missQ | (coverOff & sentQ)) & ~newAck;
    lead    = leadOnes(newAck);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx <= '0;
      spanQ <= '0;
      sentQ <= '0;
      ackQ  <= '0;
      missQ <= '0;
    end else if (strobe.load) begin
      rdIdx <= loadIdx;
      spanQ <= '0;
      sentQ <= '0;
      ackQ  <= '0;
      missQ <= '0;
    end else if (strobe.applyBa) begin
      rdIdx <= rdIdx + IDX_W'(lead);
      spanQ <= spanQ - lead;
      sentQ <= sentQ >> lead;
      ackQ  <= newAck >> lead;
      missQ <= newMiss >> lead;
    end else if (strobe.markTx) begin
      sentQ[strobe.txOff] <= 1'b1;
      missQ[strobe.txOff] <= 1'b0;
      if (strobe.txNew) spanQ <= spanQ + CNT_W'(1);
    end
  end

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.applyBa) |=> rdIdx == $past(rdIdx));
  p_load_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (spanQ == '0 && sentQ == '0 && rdIdx == $past(loadIdx)));
  p_span_max_r3: assert property (@(posedge clk) disable iff (!rstN)
    spanQ <= CNT_W'(WIN_SLOTS));
  p_ack_sent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackQ & ~sentQ) == '0);
endmodule

// File: rtl/baWinCtrl.sv
module baWinCtrl
  import baWinPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadValid,
  input  logic                 baValid,
  input  logic                 txDone,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [CNT_W-1:0]     cfgWinSize,
  input  logic [CNT_W-1:0]     cfgFrameLimit,
  input  logic [IDX_W-1:0]     rdIdx,
  input  logic [CNT_W-1:0]     spanQ,
  input  logic [WIN_SLOTS-1:0] sentQ,
  input  logic [WIN_SLOTS-1:0] ackQ,
  input  logic [WIN_SLOTS-1:0] missQ,
  output winStrobe_t           strobe,
  output logic                 offerValid,
  output logic [IDX_W-1:0]     offerIdx,
  output logic                 spaceLeft
);
  localparam logic [CNT_W-1:0] SLOT_CAP = CNT_W'(WIN_SLOTS);

  logic [IDX_W-1:0]     avail;
  logic [CNT_W-1:0]     winCap, inFlight;
  logic [WIN_SLOTS-1:0] retryVec;
  logic                 retryFound, newPick;
  logic [OFF_W-1:0]     retryOff, offerOff;

  function automatic logic [CNT_W-1:0] popCount(input logic [WIN_SLOTS-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < WIN_SLOTS; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  always_comb begin
    avail     = wrIdx - rdIdx;
    winCap    = (cfgWinSize > SLOT_CAP) ? SLOT_CAP : cfgWinSize;
    spaceLeft = (spanQ < winCap) && (IDX_W'(spanQ) < avail);
    retryVec  = missQ & sentQ & ~ackQ;
    inFlight  = popCount(sentQ & ~ackQ & ~missQ);
    retryFound = 1'b0;
    retryOff   = '0;
    for (int i = WIN_SLOTS - 1; i >= 0; i--) begin
      if (retryVec[i]) begin
        retryFound = 1'b1;
        retryOff   = OFF_W'(i);
      end
    end
    newPick    = !retryFound && spaceLeft;
    offerOff   = retryFound ? retryOff : spanQ[OFF_W-1:0];
    offerValid = (retryFound || spaceLeft) && (inFlight < cfgFrameLimit);
    offerIdx   = rdIdx + IDX_W'(offerOff);

    strobe.load    = loadValid;
    strobe.applyBa = baValid && !loadValid;
    strobe.markTx  = txDone && offerValid && !baValid && !loadValid;
    strobe.txNew   = newPick;
    strobe.txOff   = offerOff;
  end

  p_tx_grow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.markTx && strobe.txNew) |=> spanQ == $past(spanQ) + CNT_W'(1));
  p_inflight_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markTx |=> $countones(sentQ & ~ackQ & ~missQ) <= $past(cfgFrameLimit));
endmodule

// File: rtl/baWindowTracker.sv
module baWindowTracker
  import baWinPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     cfgWinSize,
  input  logic [CNT_W-1:0]     cfgFrameLimit,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic                 loadValid,
  input  logic [IDX_W-1:0]     loadIdx,
  input  logic                 baValid,
  input  logic [IDX_W-1:0]     baStart,
  input  logic [WIN_SLOTS-1:0] baBitmap,
  input  logic                 txDone,
  output logic                 offerValid,
  output logic [IDX_W-1:0]     offerIdx,
  output logic                 spaceLeft,
  output logic [IDX_W-1:0]     rdIdx
);
  winStrobe_t           strobe;
  logic [CNT_W-1:0]     spanQ;
  logic [WIN_SLOTS-1:0] sentQ, ackQ, missQ;

  baWinCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .baValid(baValid),
    .txDone(txDone), .wrIdx(wrIdx), .cfgWinSize(cfgWinSize),
    .cfgFrameLimit(cfgFrameLimit), .rdIdx(rdIdx), .spanQ(spanQ),
    .sentQ(sentQ), .ackQ(ackQ), .missQ(missQ), .strobe(strobe),
    .offerValid(offerValid), .offerIdx(offerIdx), .spaceLeft(spaceLeft)
  );

  baWinData u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadIdx(loadIdx),
    .baStart(baStart), .baBitmap(baBitmap), .rdIdx(rdIdx), .spanQ(spanQ),
    .sentQ(sentQ), .ackQ(ackQ), .missQ(missQ)
  );
endmodule

// File: tb/baWindowTracker_tb.sv
module baWindowTracker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  cfgWinSize = 7'd64, cfgFrameLimit = 7'd10;
  logic [7:0]  wrIdx = 8'd0, loadIdx = 8'd0, baStart = 8'd0;
  logic        loadValid = 1'b0, baValid = 1'b0, txDone = 1'b0;
  logic [63:0] baBitmap = '0;
  logic        offerValid, spaceLeft;
  logic [7:0]  offerIdx, rdIdx;

  always #10 clk = ~clk;

  baWindowTracker u_dut (
    .clk(clk), .rstN(rstN), .cfgWinSize(cfgWinSize), .cfgFrameLimit(cfgFrameLimit),
    .wrIdx(wrIdx), .loadValid(loadValid), .loadIdx(loadIdx), .baValid(baValid),
    .baStart(baStart), .baBitmap(baBitmap), .txDone(txDone),
    .offerValid(offerValid), .offerIdx(offerIdx), .spaceLeft(spaceLeft), .rdIdx(rdIdx)
  );

  int nChk = 0, nBad = 0;
  bit mSent[256], mAck[256], mMiss[256];
  int mRd = 0, mSpan = 0;

  task automatic check(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void modelOffer(output bit v, output int idx, output bit sp);
    int avail, win, infl;
    bit found;
    avail = (int'(wrIdx) - mRd) & 255;
    win   = (cfgWinSize > 64) ? 64 : int'(cfgWinSize);
    infl  = 0; found = 0; idx = 0;
    sp = (mSpan < win) && (mSpan < avail);
    for (int o = 0; o < mSpan; o++) begin
      int s;
      s = (mRd + o) & 255;
      if (mSent[s] && !mAck[s] && !mMiss[s]) infl++;
      if (!found && mMiss[s] && !mAck[s]) begin found = 1; idx = s; end
    end
    if (!found && sp) idx = (mRd + mSpan) & 255;
    v = (found || sp) && (infl < int'(cfgFrameLimit));
  endfunction

  // Compare outputs now, then advance the model with the inputs of the next edge.
  task automatic tick(string tag);
    bit v, sp;
    int idx;
    #1;
    modelOffer(v, idx, sp);
    check(tag, "offerValid", int'(offerValid), int'(v));
    if (v) check(tag, "offerIdx", int'(offerIdx), idx);
    check(tag, "spaceLeft", int'(spaceLeft), int'(sp));
    check(tag, "rdIdx", int'(rdIdx), mRd);
    if (loadValid) begin
      for (int s = 0; s < 256; s++) begin mSent[s] = 0; mAck[s] = 0; mMiss[s] = 0; end
      mRd = int'(loadIdx); mSpan = 0;
    end else if (baValid) begin
      for (int i = 0; i < 64; i++) begin
        int s, o;
        s = (int'(baStart) + i) & 255;
        o = (s - mRd) & 255;
        if (o < mSpan) begin
          if (baBitmap[i]) begin mAck[s] = 1; mMiss[s] = 0; end
          else if (!mAck[s]) mMiss[s] = 1;
        end
      end
      while (mSpan > 0 && mAck[mRd]) begin
        mSent[mRd] = 0; mAck[mRd] = 0; mMiss[mRd] = 0;
        mRd = (mRd + 1) & 255; mSpan--;
      end
    end else if (txDone && v) begin
      mSent[idx] = 1; mMiss[idx] = 0;
      if (idx == ((mRd + mSpan) & 255)) mSpan++;
    end
    @(negedge clk);
    loadValid = 0; baValid = 0; txDone = 0;
  endtask

  initial begin
    #(20 * 200000);
    nBad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    tick("R1");
    check("R1", "rdIdx after reset", int'(rdIdx), 0);
    check("R1", "spaceLeft empty queue", int'(spaceLeft), 0);
    // R2: fresh frames in order
    wrIdx = 8'd5;
    for (int k = 0; k < 6; k++) begin txDone = 1; tick("R2"); end
    // R4: frame limit below in-flight count
    cfgFrameLimit = 7'd3; wrIdx = 8'd10;
    for (int k = 0; k < 3; k++) begin txDone = 1; tick("R4"); end
    check("R4", "offer blocked at limit", int'(offerValid), 0);
    // R6 R7: ack 0,2,4 miss 1,3
    baValid = 1; baStart = 8'd0; baBitmap = 64'b10101; tick("R6");
    check("R6", "rdIdx advanced", int'(rdIdx), 1);
    check("R7", "retry lowest offset", int'(offerIdx), 1);
    for (int k = 0; k < 3; k++) begin txDone = 1; tick("R7"); end
    // R5: bits beyond sent frames ignored
    baValid = 1; baStart = 8'd45; baBitmap = '1; tick("R5");
    check("R5", "rdIdx unchanged", int'(rdIdx), 1);
    // R9: block-ack wins over txDone
    cfgFrameLimit = 7'd20;
    baValid = 1; txDone = 1; baStart = 8'd1; baBitmap = 64'h1; tick("R9");
    tick("R9");
    // R3: small window and clamp
    loadValid = 1; loadIdx = 8'd20; wrIdx = 8'd20; tick("R8");
    check("R8", "rdIdx loaded", int'(rdIdx), 20);
    wrIdx = 8'd40; cfgWinSize = 7'd2;
    for (int k = 0; k < 4; k++) begin txDone = 1; tick("R3"); end
    check("R3", "window full", int'(spaceLeft), 0);
    cfgWinSize = 7'd100;
    for (int k = 0; k < 3; k++) begin txDone = 1; tick("R3"); end
    // R10: wrap around 255
    loadValid = 1; loadIdx = 8'd250; wrIdx = 8'd250; tick("R8");
    wrIdx = 8'd14;
    for (int k = 0; k < 12; k++) begin txDone = 1; tick("R10"); end
    baValid = 1; baStart = 8'd250; baBitmap = 64'hFFF; tick("R10");
    check("R10", "rdIdx wrapped", int'(rdIdx), 6);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      if (((int'(wrIdx) - mRd) & 255) < 120) wrIdx = wrIdx + 8'($urandom_range(0, 2));
      if ($urandom_range(0, 99) < 3) cfgFrameLimit = 7'($urandom_range(0, 70));
      if ($urandom_range(0, 99) < 3) cfgWinSize = 7'($urandom_range(0, 127));
      txDone = ($urandom_range(0, 99) < 70);
      if ($urandom_range(0, 99) < 12) begin
        baValid = 1;
        baStart = 8'((mRd + $urandom_range(0, 24) + 248) & 255);
        baBitmap = {$urandom, $urandom} | {$urandom, $urandom};
      end
      if ($urandom_range(0, 999) < 4) begin
        loadValid = 1; loadIdx = 8'($urandom); wrIdx = loadIdx;
      end
      tick("R7");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule